// File: doc/BRIEF.md
# Virtual-Channel Input Buffer

This block sits on the receiving side of one router port. A single physical link delivers at most one flit per cycle, and every flit names the virtual channel (VC) it belongs to. The block files each flit into a private queue for that VC. Because each packet's flits stay in order and carry only their VC number as identity, keeping one queue per VC lets several packets share the link in interleaved fashion without their flits mixing.

Downstream allocation logic sees the oldest flit of every VC and a not-empty flag per VC. It drains a queue through a per-VC read strobe. Each flit removed frees one slot. The block reports that slot upstream as a one-cycle credit pulse tagged with the VC number, so that the sender can raise its credit count for that VC. The block also tracks, per VC, whether a packet is open at the queue output: it opens when a head flit leaves and closes when the tail leaves. This is the condition that frees the VC. A flit that arrives for a full queue points to a broken credit loop. Such a flit is discarded and recorded in a sticky error flag.

Top module: `vc_input_buffer`

## Requirements
- R1: After reset, every queue is empty, `vc_nonempty` is all zero, `credit_valid` is low, `overflow_err` is low and `vc_pkt_open` is all zero.
- R2: A flit is laid out as {kind[1:0], vc[VC_W-1:0], payload[PAYLOAD_W-1:0]}, with kind in the top two bits. The kind codes are 00 head, 01 body, 10 tail and 11 single-flit packet. When `in_valid` is high, the whole flit is stored in the queue of the VC named by its vc field.
- R3: Each VC queue is first-in first-out and holds up to DEPTH flits. Traffic on one VC does not change the contents or the order of another VC's queue.
- R4: `vc_nonempty[v]` is high exactly when queue v holds at least one flit. While it is high, slice v of `head_flits` shows the oldest flit of queue v.
- R5: When several VCs with stored flits are strobed in the same cycle, only the lowest-numbered one is dequeued in that cycle.
- R6: A dequeue raises `credit_valid` in the same cycle, with `credit_vc` set to the dequeued VC. There is at most one credit per cycle, and no credit is issued without a dequeue.
- R7: A read strobe on an empty VC has no effect and produces no credit.
- R8: A flit that arrives for a VC whose queue already held DEPTH flits at the start of the cycle is discarded, even if the same VC is read in that cycle. It sets `overflow_err`, which stays high until reset.
- R9: `vc_pkt_open[v]` is set on the cycle after a head flit (00) is dequeued from VC v. It is cleared on the cycle after a tail flit (10) is dequeued from VC v. Body flits (01) and single-flit packets (11) leave it unchanged.
- R10: A write and a dequeue on the same non-full VC in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Incoming flit is valid this cycle |
| in_flit | input | FLIT_W | Incoming flit {kind, vc, payload} |
| rd_req | input | NUM_VC | Per-VC read strobe from downstream |
| vc_nonempty | output | NUM_VC | Queue v holds at least one flit |
| head_flits | output | NUM_VC*FLIT_W | Oldest flit of each VC, VC v in slice v |
| credit_valid | output | 1 | A slot was freed this cycle |
| credit_vc | output | VC_W | VC whose slot was freed |
| vc_pkt_open | output | NUM_VC | Packet open at the output of VC v |
| overflow_err | output | 1 | Sticky: a flit arrived for a full queue |

## Verification
The bench builds the block with four VCs, a queue depth of three and 8-bit payloads. A depth that is not a power of two forces both pointers through their explicit wrap at index two. A shallow queue lets the bench reach the full-queue drop, including a drop while the full queue is being read in the same cycle, after only a few writes. With four VCs the bench can strobe several non-empty queues at once and confirm that the lowest-numbered one wins, while also interleaving packets on distinct VCs.

// File: rtl/vcib_pkg.sv
package vcib_pkg;
    typedef enum logic [1:0] {
        KIND_HEAD   = 2'b00,
        KIND_BODY   = 2'b01,
        KIND_TAIL   = 2'b10,
        KIND_SINGLE = 2'b11
    } flit_kind_e;
endpackage

// File: rtl/vcib_fifo.sv
module vcib_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wr;
        logic [PW-1:0]           rd;
        logic [CW-1:0]           cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (push) begin
            st_d.mem[st_q.wr] = din;
            st_d.wr = (st_q.wr == PW'(DEPTH - 1)) ? '0 : st_q.wr + PW'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == PW'(DEPTH - 1)) ? '0 : st_q.rd + PW'(1);
        end
        case ({push, pop})
            2'b10:   st_d.cnt = st_q.cnt + CW'(1);
            2'b01:   st_d.cnt = st_q.cnt - CW'(1);
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dout  = st_q.mem[st_q.rd];
    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CW'(DEPTH));

    AST_FIFO_POP_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty); // R7
    AST_FIFO_NO_WRITE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R8
    AST_FIFO_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH)); // R3
endmodule

// File: rtl/vcib_rd_sel.sv
module vcib_rd_sel #(
    parameter int NUM_VC = 4
) (
    input  logic [NUM_VC-1:0]         rd_req,
    input  logic [NUM_VC-1:0]         nonempty,
    output logic [NUM_VC-1:0]         pop_oh,
    output logic                      pop_any,
    output logic [$clog2(NUM_VC)-1:0] pop_vc
);
    localparam int VC_W = $clog2(NUM_VC);

    logic [NUM_VC-1:0] elig;

    always_comb begin
        elig    = rd_req & nonempty;
        pop_oh  = '0;
        pop_any = 1'b0;
        pop_vc  = '0;
        for (int v = NUM_VC - 1; v >= 0; v--) begin
            if (elig[v]) begin
                pop_oh  = '0;
                pop_oh[v] = 1'b1;
                pop_any = 1'b1;
                pop_vc  = VC_W'(v);
            end
        end
    end
endmodule

// File: rtl/vcib_pkt_track.sv
module vcib_pkt_track
    import vcib_pkg::*;
#(
    parameter int NUM_VC = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      pop_any,
    input  logic [$clog2(NUM_VC)-1:0] pop_vc,
    input  logic [1:0]                pop_kind,
    output logic [NUM_VC-1:0]         open
);
    typedef struct packed {
        logic [NUM_VC-1:0] open;
    } trk_st_t;

    trk_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (pop_any) begin
            if (pop_kind == KIND_HEAD)      st_d.open[pop_vc] = 1'b1;
            else if (pop_kind == KIND_TAIL) st_d.open[pop_vc] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open = st_q.open;

    AST_TAIL_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_any && pop_kind == KIND_TAIL) |=> !open[$past(pop_vc)]); // R9
    AST_HEAD_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_any && pop_kind == KIND_HEAD) |=> open[$past(pop_vc)]); // R9
endmodule

// File: rtl/vc_input_buffer.sv
module vc_input_buffer
    import vcib_pkg::*;
#(
    parameter int NUM_VC    = 4,
    parameter int DEPTH     = 4,
    parameter int PAYLOAD_W = 32,
    localparam int VC_W     = $clog2(NUM_VC),
    localparam int FLIT_W   = 2 + VC_W + PAYLOAD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [FLIT_W-1:0]        in_flit,
    input  logic [NUM_VC-1:0]        rd_req,
    output logic [NUM_VC-1:0]        vc_nonempty,
    output logic [NUM_VC*FLIT_W-1:0] head_flits,
    output logic                     credit_valid,
    output logic [VC_W-1:0]          credit_vc,
    output logic [NUM_VC-1:0]        vc_pkt_open,
    output logic                     overflow_err
);
    localparam int VC_LSB = PAYLOAD_W;

    typedef struct packed {
        logic ovf;
    } top_st_t;

    top_st_t           st_d, st_q;
    logic [VC_W-1:0]   in_vc;
    logic              in_vc_ok;
    logic [NUM_VC-1:0] full_v;
    logic [NUM_VC-1:0] empty_v;
    logic [NUM_VC-1:0] push_v;
    logic [NUM_VC-1:0] pop_oh;
    logic              pop_any;
    logic [VC_W-1:0]   pop_vc;
    logic [FLIT_W-1:0] pop_flit;

    assign in_vc    = in_flit[VC_LSB +: VC_W];
    assign in_vc_ok = (int'(in_vc) < NUM_VC);

    always_comb begin
        st_d   = st_q;
        push_v = '0;
        if (in_valid && in_vc_ok) begin
            if (full_v[in_vc]) st_d.ovf = 1'b1;
            else               push_v[in_vc] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        for (genvar v = 0; v < NUM_VC; v++) begin : g_vc
            vcib_fifo #(
                .DEPTH (DEPTH),
                .W     (FLIT_W)
            ) i_fifo (
                .clk   (clk),
                .rst_n (rst_n),
                .push  (push_v[v]),
                .din   (in_flit),
                .pop   (pop_oh[v]),
                .dout  (head_flits[v*FLIT_W +: FLIT_W]),
                .empty (empty_v[v]),
                .full  (full_v[v])
            );
        end
    endgenerate

    assign vc_nonempty = ~empty_v;

    vcib_rd_sel #(
        .NUM_VC (NUM_VC)
    ) i_rd_sel (
        .rd_req   (rd_req),
        .nonempty (vc_nonempty),
        .pop_oh   (pop_oh),
        .pop_any  (pop_any),
        .pop_vc   (pop_vc)
    );

    assign pop_flit = head_flits[pop_vc*FLIT_W +: FLIT_W];

    vcib_pkt_track #(
        .NUM_VC (NUM_VC)
    ) i_pkt_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .pop_any  (pop_any),
        .pop_vc   (pop_vc),
        .pop_kind (pop_flit[FLIT_W-1 -: 2]),
        .open     (vc_pkt_open)
    );

    assign credit_valid = pop_any;
    assign credit_vc    = pop_vc;
    assign overflow_err = st_q.ovf;

    AST_CREDIT_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> vc_nonempty[credit_vc]); // R7
    AST_CREDIT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> rd_req[credit_vc]); // R6
    AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        credit_valid |-> ((rd_req & vc_nonempty & ((NUM_VC'(1) << credit_vc) - NUM_VC'(1))) == '0)); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overflow_err |=> overflow_err); // R8
    AST_FULL_WRITE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_vc_ok && full_v[in_vc]) |=> overflow_err); // R8
endmodule

// File: tb/test_vc_input_buffer.sv
module test_vc_input_buffer;
    localparam int NV  = 4;
    localparam int DP  = 3;
    localparam int PLW = 8;
    localparam int VW  = 2;
    localparam int FW  = 2 + VW + PLW;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_valid = 1'b0;
    logic [FW-1:0]   in_flit = '0;
    logic [NV-1:0]   rd_req = '0;
    logic [NV-1:0]   vc_nonempty;
    logic [NV*FW-1:0] head_flits;
    logic            credit_valid;
    logic [VW-1:0]   credit_vc;
    logic [NV-1:0]   vc_pkt_open;
    logic            overflow_err;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    logic [FW-1:0] exp_q [NV][$];
    logic [NV-1:0] exp_open = '0;
    logic          exp_ovf = 1'b0;

    always #4 clk = ~clk;

    vc_input_buffer #(
        .NUM_VC    (NV),
        .DEPTH     (DP),
        .PAYLOAD_W (PLW)
    ) i_vc_input_buffer (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_flit      (in_flit),
        .rd_req       (rd_req),
        .vc_nonempty  (vc_nonempty),
        .head_flits   (head_flits),
        .credit_valid (credit_valid),
        .credit_vc    (credit_vc),
        .vc_pkt_open  (vc_pkt_open),
        .overflow_err (overflow_err)
    );

    function automatic logic [FW-1:0] mk(input logic [1:0] kind, input int vc, input int pl);
        return {kind, VW'(vc), PLW'(pl)};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // monitor: compares outputs against the scoreboard queues
    task automatic monitor(input string req);
        int  cv;
        bit  cval;
        cval = 1'b0;
        cv   = 0;
        for (int v = NV - 1; v >= 0; v--) begin
            if (rd_req[v] && exp_q[v].size() > 0) begin
                cval = 1'b1;
                cv   = v;
            end
        end
        for (int v = 0; v < NV; v++) begin
            check(vc_nonempty[v] == (exp_q[v].size() > 0), {req, "/R4 nonempty"},
                  64'(vc_nonempty[v]), 64'(exp_q[v].size() > 0));
            if (exp_q[v].size() > 0)
                check(head_flits[v*FW +: FW] == exp_q[v][0], {req, "/R3 head"},
                      64'(head_flits[v*FW +: FW]), 64'(exp_q[v][0]));
        end
        check(credit_valid == cval, {req, "/R6 credit_valid"}, 64'(credit_valid), 64'(cval));
        if (cval)
            check(credit_vc == VW'(cv), {req, "/R5 credit_vc"}, 64'(credit_vc), 64'(cv));
        check(overflow_err == exp_ovf, {req, "/R8 overflow"}, 64'(overflow_err), 64'(exp_ovf));
        check(vc_pkt_open == exp_open, {req, "/R9 pkt_open"}, 64'(vc_pkt_open), 64'(exp_open));
    endtask

    // driver: applies one cycle of stimulus and advances the scoreboard
    task automatic step(input bit v, input logic [FW-1:0] f, input logic [NV-1:0] rd, input string req);
        int wvc;
        bit drop;
        int pv;
        @(negedge clk);
        in_valid = v;
        in_flit  = f;
        rd_req   = rd;
        #1;
        monitor(req);
        wvc  = int'(f[PLW +: VW]);
        drop = v && (exp_q[wvc].size() == DP);
        pv   = -1;
        for (int k = NV - 1; k >= 0; k--)
            if (rd[k] && exp_q[k].size() > 0) pv = k;
        @(posedge clk);
        if (pv >= 0) begin
            case (exp_q[pv][0][FW-1 -: 2])
                2'b00: exp_open[pv] = 1'b1;
                2'b10: exp_open[pv] = 1'b0;
                default: ;
            endcase
            void'(exp_q[pv].pop_front());
        end
        if (drop) exp_ovf = 1'b1;
        else if (v) exp_q[wvc].push_back(f);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        #1;
        // R1: reset state
        check(vc_nonempty == '0, "R1 nonempty", 64'(vc_nonempty), 64'd0);
        check(credit_valid == 1'b0, "R1 credit", 64'(credit_valid), 64'd0);
        check(overflow_err == 1'b0, "R1 overflow", 64'(overflow_err), 64'd0);
        check(vc_pkt_open == '0, "R1 pkt_open", 64'(vc_pkt_open), 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, '0, '0, "R1");

        // R2 R3: interleaved writes across VCs
        step(1, mk(2'b00, 0, 8'h11), '0, "R2");
        step(1, mk(2'b01, 2, 8'h22), '0, "R2");
        step(1, mk(2'b01, 0, 8'h33), '0, "R2");
        step(1, mk(2'b10, 3, 8'h44), '0, "R2");
        step(1, mk(2'b11, 1, 8'h55), '0, "R3");
        step(1, mk(2'b10, 0, 8'h66), '0, "R3");
        // R5: several strobes, lowest wins
        step(0, '0, 4'b1111, "R5");
        step(0, '0, 4'b1110, "R5");
        step(0, '0, 4'b1100, "R5");
        step(0, '0, 4'b1001, "R5");
        step(0, '0, 4'b1001, "R9");
        step(0, '0, 4'b1000, "R6");
        // R7: read of empty VC
        step(0, '0, 4'b0100, "R7");
        step(0, '0, 4'b1111, "R7");
        // R10: write and read same VC
        step(1, mk(2'b00, 2, 8'h77), '0, "R10");
        step(1, mk(2'b01, 2, 8'h88), 4'b0100, "R10");
        step(1, mk(2'b10, 2, 8'h99), 4'b0100, "R10");
        step(0, '0, 4'b0100, "R9");
        // R8: fill VC3 and overflow, including full-while-read
        step(1, mk(2'b00, 3, 8'hA1), '0, "R8");
        step(1, mk(2'b01, 3, 8'hA2), '0, "R8");
        step(1, mk(2'b01, 3, 8'hA3), '0, "R8");
        step(1, mk(2'b10, 3, 8'hA4), '0, "R8");
        step(1, mk(2'b10, 3, 8'hA5), 4'b1000, "R8");
        step(1, mk(2'b10, 3, 8'hA6), '0, "R8");
        for (int i = 0; i < 5; i++) step(0, '0, 4'b1000, "R8");
        // R3: wraparound on every VC
        for (int r = 0; r < 3; r++) begin
            for (int v = 0; v < NV; v++) step(1, mk(2'b01, v, r * 16 + v), '0, "R3");
            for (int v = 0; v < NV; v++) step(1, mk(2'b01, v, r * 16 + v + 8), 4'b0001 << v, "R3");
        end
        for (int i = 0; i < 12; i++) step(0, '0, 4'b1111, "R4");
        step(0, '0, '0, "R4");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule